// File: doc/BRIEF.md
# Incremental step pulse switching controller

This block automates the search for the switching point of a resistive memory cell. For each run it first measures the cell's resistance as a baseline. It then issues write pulses of fixed width, each followed by one resistance read. Pulse magnitude begins at a programmed start value and rises by a programmed step after every pulse. A run that drives the cell past its resistance target closes with a switching voltage, which is the signed amplitude of the last pulse. A run that would need a pulse above the programmed maximum closes with a fail flag instead. Successive runs alternate polarity, so positive (set-direction) and negative (reset-direction) searches interleave.

Alongside the switching voltage, each run reports a threshold voltage. This is the first pulse amplitude after which the resistance differs from the baseline by more than 2%. The test multiplies the resistance difference by 50 and compares it with the baseline, so no divider is needed. The pulse generator and the resistance measurement sit outside the block. The block talks to them through valid/ready channels.

Each finished run produces one record. The record goes into a small output FIFO that a host or buffer drains through a valid/ready port. A full FIFO stalls the search, and no record is lost. The configuration is captured when `start` is accepted.

Top module: `ispp_search_ctrl`

## Requirements
- R1: While reset is asserted, and after it until `start` is accepted, `busy`, `pls_valid`, `rd_req_valid` and `rec_valid` are low.
- R2: Every run begins with one read request before its first pulse. Between two consecutive pulses there is exactly one read. The number of reads in a session equals the number of pulses plus the number of runs.
- R3: Within a run the n-th pulse (n from 0) has magnitude `cfg_start_mv + n*cfg_step_mv`. `pls_amp_mv` is a two's-complement millivolt value: positive for a positive-polarity run, negated for a negative-polarity run.
- R4: The first run has negative polarity when `cfg_first_neg` is 1 and positive polarity otherwise. Each following run takes the opposite polarity of the one before. `rec_neg` reports the run's polarity.
- R5: A positive run ends successfully on the first read after a pulse with resistance <= `cfg_r_lo`. A negative run ends successfully on the first such read with resistance >= `cfg_r_hi`. The record then has `rec_fail`=0 and `rec_sw_mv` equal to the signed amplitude of that last pulse.
- R6: With R0 as the run's baseline read, `rec_th_mv` is the signed amplitude of the first pulse whose following read Rc satisfies 50*|Rc-R0| > R0, and `rec_th_seen` is 1. If no read in the run satisfies this, `rec_th_seen`=0 and `rec_th_mv`=0.
- R7: A pulse is issued only while its magnitude is <= `cfg_max_mv`. When the next magnitude would exceed it, the run ends with `rec_fail`=1 and `rec_sw_mv`=0. This includes a run whose start value already exceeds the maximum, which issues no pulse.
- R8: An accepted `start` produces exactly `cfg_runs` records and then `busy` falls. `start` is ignored while `busy` is high and when `cfg_runs` is 0. Configuration changes after acceptance have no effect on the session.
- R9: Records leave in run order through a FIFO of `REC_DEPTH` entries. While `rec_valid` is high and `rec_ready` low, all record outputs hold. When the FIFO is full the search waits, and no record is dropped.
- R10: Once `pls_valid` is raised it stays high with `pls_amp_mv` unchanged until `pls_ready` is seen. Once `rd_req_valid` is raised it stays high until `rd_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a session (captures configuration) |
| cfg_start_mv | input | AMP_W-1 | Magnitude of the first pulse of each run, mV |
| cfg_step_mv | input | AMP_W-1 | Magnitude increment per pulse, mV |
| cfg_max_mv | input | AMP_W-1 | Largest permitted pulse magnitude, mV |
| cfg_r_lo | input | RES_W | Lower resistance target, ohm (positive runs) |
| cfg_r_hi | input | RES_W | Upper resistance target, ohm (negative runs) |
| cfg_runs | input | RUN_W | Number of runs in the session |
| cfg_first_neg | input | 1 | Polarity of the first run (1 = negative) |
| busy | output | 1 | Session in progress |
| pls_valid | output | 1 | Pulse request valid |
| pls_ready | input | 1 | Pulse generator accepts request |
| pls_amp_mv | output | AMP_W | Signed pulse amplitude, mV |
| rd_req_valid | output | 1 | Resistance read request valid |
| rd_req_ready | input | 1 | Measurement accepts read request |
| rd_res_valid | input | 1 | Read result valid |
| rd_res_ready | output | 1 | Controller accepts read result |
| rd_res_ohm | input | RES_W | Measured resistance, ohm |
| rec_valid | output | 1 | Run record valid |
| rec_ready | input | 1 | Consumer accepts run record |
| rec_neg | output | 1 | Run polarity (1 = negative) |
| rec_sw_mv | output | AMP_W | Signed switching voltage, 0 on fail |
| rec_th_mv | output | AMP_W | Signed threshold voltage, 0 if not seen |
| rec_th_seen | output | 1 | Threshold departure observed |
| rec_fail | output | 1 | Run hit the amplitude limit |

## Verification
The assertions assume the following about the inputs. Configuration magnitudes fit in AMP_W-1 bits. The step is non-zero, so every run ends. A read result is presented only after a read request has been accepted, and it is held until `rd_res_ready` takes it. The bench responds as a well-behaved pulse generator and measurement unit. It raises a result only a few cycles after it accepts a request, and it holds that result until the transfer. It uses a step of at least 25 mV and keeps the start and maximum well below the signed range. Its random ready patterns on all three channels, including long record stalls, exercise back-pressure without breaking these rules.

// File: rtl/ispp_pkg.sv
package ispp_pkg;

  // controller sequencing states
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BASE_REQ,
    ST_BASE_WAIT,
    ST_LIMIT,
    ST_PULSE,
    ST_MEAS_REQ,
    ST_MEAS_WAIT,
    ST_EMIT
  } ispp_state_e;

  // 2 % departure: 50 * |Rc - R0| > R0
  localparam int DEPART_SCALE = 50;
  localparam int DEPART_BITS  = 6;

endpackage

// File: rtl/ispp_dev_check.sv
module ispp_dev_check #(
  parameter int RES_W = 24
) (
  input  logic [RES_W-1:0] rc,
  input  logic [RES_W-1:0] r0,
  input  logic [RES_W-1:0] r_lo,
  input  logic [RES_W-1:0] r_hi,
  input  logic             neg,
  output logic             departed,
  output logic             reached
);
  localparam int DW = RES_W + ispp_pkg::DEPART_BITS;

  logic [RES_W-1:0] diff;
  logic [DW-1:0]    scaled;

  always_comb begin
    diff     = (rc >= r0) ? (rc - r0) : (r0 - rc);
    scaled   = DW'(diff) * DW'(ispp_pkg::DEPART_SCALE);
    departed = scaled > DW'(r0);
    reached  = neg ? (rc >= r_hi) : (rc <= r_lo);
  end

endmodule

// File: rtl/ispp_ramp_fsm.sv
module ispp_ramp_fsm
  import ispp_pkg::*;
#(
  parameter int AMP_W = 16,
  parameter int RES_W = 24,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AMP_W-2:0] cfg_start_mv,
  input  logic [AMP_W-2:0] cfg_step_mv,
  input  logic [AMP_W-2:0] cfg_max_mv,
  input  logic [RES_W-1:0] cfg_r_lo,
  input  logic [RES_W-1:0] cfg_r_hi,
  input  logic [RUN_W-1:0] cfg_runs,
  input  logic             cfg_first_neg,
  output logic             busy,
  output logic             pls_valid,
  input  logic             pls_ready,
  output logic [AMP_W-1:0] pls_amp,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  input  logic             rd_res_valid,
  output logic             rd_res_ready,
  input  logic [RES_W-1:0] rd_res_ohm,
  output logic             push,
  input  logic             full,
  output logic             out_neg,
  output logic [AMP_W-1:0] out_sw,
  output logic [AMP_W-1:0] out_th,
  output logic             out_th_seen,
  output logic             out_fail
);

  ispp_state_e state_q;

  logic [AMP_W-2:0] start_q, step_q, max_q;
  logic [RES_W-1:0] r_lo_q, r_hi_q, r0_q;
  logic [RUN_W-1:0] runs_left_q;
  logic             neg_q;
  logic [AMP_W-1:0] mag_q;
  logic             th_seen_q, fail_q;
  logic [AMP_W-1:0] th_q, sw_q;

  logic signed [AMP_W-1:0] amp_s;
  logic                    departed, reached;

  assign amp_s = neg_q ? -$signed(mag_q) : $signed(mag_q);

  ispp_dev_check #(.RES_W(RES_W)) u_check (
    .rc       (rd_res_ohm),
    .r0       (r0_q),
    .r_lo     (r_lo_q),
    .r_hi     (r_hi_q),
    .neg      (neg_q),
    .departed (departed),
    .reached  (reached)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      start_q     <= '0;
      step_q      <= '0;
      max_q       <= '0;
      r_lo_q      <= '0;
      r_hi_q      <= '0;
      r0_q        <= '0;
      runs_left_q <= '0;
      neg_q       <= 1'b0;
      mag_q       <= '0;
      th_seen_q   <= 1'b0;
      th_q        <= '0;
      sw_q        <= '0;
      fail_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start && (cfg_runs != '0)) begin
            start_q     <= cfg_start_mv;
            step_q      <= cfg_step_mv;
            max_q       <= cfg_max_mv;
            r_lo_q      <= cfg_r_lo;
            r_hi_q      <= cfg_r_hi;
            runs_left_q <= cfg_runs;
            neg_q       <= cfg_first_neg;
            state_q     <= ST_BASE_REQ;
          end
        end
        ST_BASE_REQ: if (rd_req_ready) state_q <= ST_BASE_WAIT;
        ST_BASE_WAIT: begin
          if (rd_res_valid) begin
            r0_q      <= rd_res_ohm;
            mag_q     <= {1'b0, start_q};
            th_seen_q <= 1'b0;
            th_q      <= '0;
            state_q   <= ST_LIMIT;
          end
        end
        ST_LIMIT: begin
          if (mag_q > {1'b0, max_q}) begin
            sw_q    <= '0;
            fail_q  <= 1'b1;
            state_q <= ST_EMIT;
          end else begin
            state_q <= ST_PULSE;
          end
        end
        ST_PULSE: if (pls_ready) state_q <= ST_MEAS_REQ;
        ST_MEAS_REQ: if (rd_req_ready) state_q <= ST_MEAS_WAIT;
        ST_MEAS_WAIT: begin
          if (rd_res_valid) begin
            if (departed && !th_seen_q) begin
              th_seen_q <= 1'b1;
              th_q      <= amp_s;
            end
            if (reached) begin
              sw_q    <= amp_s;
              fail_q  <= 1'b0;
              state_q <= ST_EMIT;
            end else begin
              mag_q   <= mag_q + {1'b0, step_q};
              state_q <= ST_LIMIT;
            end
          end
        end
        ST_EMIT: begin
          if (!full) begin
            runs_left_q <= runs_left_q - RUN_W'(1);
            neg_q       <= ~neg_q;
            state_q     <= (runs_left_q == RUN_W'(1)) ? ST_IDLE : ST_BASE_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign pls_valid    = (state_q == ST_PULSE);
  assign pls_amp      = amp_s;
  assign rd_req_valid = (state_q == ST_BASE_REQ) || (state_q == ST_MEAS_REQ);
  assign rd_res_ready = (state_q == ST_BASE_WAIT) || (state_q == ST_MEAS_WAIT);
  assign push         = (state_q == ST_EMIT) && !full;
  assign out_neg      = neg_q;
  assign out_sw       = sw_q;
  assign out_th       = th_q;
  assign out_th_seen  = th_seen_q;
  assign out_fail     = fail_q;

  // R10: pulse request held with a stable amplitude until accepted
  assert_pls_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pls_valid && !pls_ready) |=> (pls_valid && $stable(pls_amp)));

  // R10: read request held until accepted
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid);

  // R2: an accepted pulse is followed directly by a read request
  assert_read_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pls_valid && pls_ready) |=> (rd_req_valid && !pls_valid));

  // R7: no pulse magnitude above the captured maximum
  assert_amp_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pls_valid |-> (mag_q <= {1'b0, max_q}));

  // R8: an idle controller drives no request
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pls_valid && !rd_req_valid && !rd_res_ready && !push));

endmodule

// File: rtl/ispp_rec_fifo.sv
module ispp_rec_fifo #(
  parameter int W     = 35,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign full      = (cnt_q == CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign pop       = out_valid && out_ready;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= nxt(wr_q);
      if (pop)  rd_q <= nxt(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + CW'(1);
      else if (pop && !push) cnt_q <= cnt_q - CW'(1);
    end
  end

  // R9: the controller never pushes into a full FIFO
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));

  // R9: a stalled record holds its contents
  assert_rec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/ispp_search_ctrl.sv
module ispp_search_ctrl #(
  parameter int AMP_W     = 16,
  parameter int RES_W     = 24,
  parameter int RUN_W     = 8,
  parameter int REC_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AMP_W-2:0] cfg_start_mv,
  input  logic [AMP_W-2:0] cfg_step_mv,
  input  logic [AMP_W-2:0] cfg_max_mv,
  input  logic [RES_W-1:0] cfg_r_lo,
  input  logic [RES_W-1:0] cfg_r_hi,
  input  logic [RUN_W-1:0] cfg_runs,
  input  logic             cfg_first_neg,
  output logic             busy,
  output logic             pls_valid,
  input  logic             pls_ready,
  output logic [AMP_W-1:0] pls_amp_mv,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  input  logic             rd_res_valid,
  output logic             rd_res_ready,
  input  logic [RES_W-1:0] rd_res_ohm,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic             rec_neg,
  output logic [AMP_W-1:0] rec_sw_mv,
  output logic [AMP_W-1:0] rec_th_mv,
  output logic             rec_th_seen,
  output logic             rec_fail
);
  localparam int REC_W = 2 * AMP_W + 3;

  logic             push, full;
  logic             f_neg, f_seen, f_fail;
  logic [AMP_W-1:0] f_sw, f_th;
  logic [REC_W-1:0] rec_in, rec_out;

  ispp_ramp_fsm #(.AMP_W(AMP_W), .RES_W(RES_W), .RUN_W(RUN_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cfg_start_mv  (cfg_start_mv),
    .cfg_step_mv   (cfg_step_mv),
    .cfg_max_mv    (cfg_max_mv),
    .cfg_r_lo      (cfg_r_lo),
    .cfg_r_hi      (cfg_r_hi),
    .cfg_runs      (cfg_runs),
    .cfg_first_neg (cfg_first_neg),
    .busy          (busy),
    .pls_valid     (pls_valid),
    .pls_ready     (pls_ready),
    .pls_amp       (pls_amp_mv),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_res_valid  (rd_res_valid),
    .rd_res_ready  (rd_res_ready),
    .rd_res_ohm    (rd_res_ohm),
    .push          (push),
    .full          (full),
    .out_neg       (f_neg),
    .out_sw        (f_sw),
    .out_th        (f_th),
    .out_th_seen   (f_seen),
    .out_fail      (f_fail)
  );

  assign rec_in = {f_neg, f_sw, f_th, f_seen, f_fail};

  ispp_rec_fifo #(.W(REC_W), .DEPTH(REC_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (rec_in),
    .full      (full),
    .out_valid (rec_valid),
    .out_ready (rec_ready),
    .out_data  (rec_out)
  );

  assign {rec_neg, rec_sw_mv, rec_th_mv, rec_th_seen, rec_fail} = rec_out;

endmodule

// File: tb/ispp_search_ctrl_tb.sv
`timescale 1ns/1ps
module ispp_search_ctrl_tb;
  localparam int AMP_W = 16;
  localparam int RES_W = 24;
  localparam int RUN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AMP_W-2:0] cfg_start_mv = '0, cfg_step_mv = '0, cfg_max_mv = '0;
  logic [RES_W-1:0] cfg_r_lo = '0, cfg_r_hi = '0;
  logic [RUN_W-1:0] cfg_runs = '0;
  logic cfg_first_neg = 1'b0;
  logic busy, pls_valid, rd_req_valid, rd_res_ready, rec_valid;
  logic pls_ready = 1'b0, rd_req_ready = 1'b0, rd_res_valid = 1'b0, rec_ready = 1'b0;
  logic [AMP_W-1:0] pls_amp_mv, rec_sw_mv, rec_th_mv;
  logic [RES_W-1:0] rd_res_ohm = '0;
  logic rec_neg, rec_th_seen, rec_fail;

  always #2 clk = ~clk;

  ispp_search_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_start_mv(cfg_start_mv), .cfg_step_mv(cfg_step_mv), .cfg_max_mv(cfg_max_mv),
    .cfg_r_lo(cfg_r_lo), .cfg_r_hi(cfg_r_hi), .cfg_runs(cfg_runs),
    .cfg_first_neg(cfg_first_neg), .busy(busy),
    .pls_valid(pls_valid), .pls_ready(pls_ready), .pls_amp_mv(pls_amp_mv),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_res_valid(rd_res_valid), .rd_res_ready(rd_res_ready), .rd_res_ohm(rd_res_ohm),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_neg(rec_neg),
    .rec_sw_mv(rec_sw_mv), .rec_th_mv(rec_th_mv), .rec_th_seen(rec_th_seen),
    .rec_fail(rec_fail)
  );

  int tests = 0, fails = 0;
  bit abort = 0;

  // session configuration and device model
  int g_start, g_step, g_max, g_lo, g_hi, g_runs, g_neg;
  int setv, rstv, shf, stall_mode = 0;
  int dev_r = 8000;

  // expected values
  int exp_amp [0:2047];
  int e_neg [0:63], e_sw [0:63], e_th [0:63], e_seen [0:63], e_fail [0:63];
  int np = 0, nrec = 0;

  // observation counters
  int pi = 0, ri = 0, nreads = 0;
  bit rd_flag = 0, pend = 0, res_fire = 0, prev_pwait = 0;
  int lat = 0, prev_amp = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dev_apply(input int r, input int a);
    if (a > 0 && a >= setv) return r - (r >>> shf);
    if (a < 0 && -a >= rstv) return r + (r >>> shf);
    return r;
  endfunction

  task automatic build_expected(input int init_r);
    int r, neg;
    r = init_r; neg = g_neg; np = 0; nrec = 0;
    for (int run = 0; run < g_runs; run++) begin
      int r0, mag, seen, th, sw, fl;
      r0 = r; mag = g_start; seen = 0; th = 0; sw = 0; fl = 0;
      forever begin
        int a, d;
        if (mag > g_max) begin fl = 1; sw = 0; break; end
        a = neg ? -mag : mag;
        exp_amp[np] = a; np++;
        r = dev_apply(r, a);
        d = (r >= r0) ? r - r0 : r0 - r;
        if (!seen && 50 * d > r0) begin seen = 1; th = a; end
        if (neg ? (r >= g_hi) : (r <= g_lo)) begin sw = a; break; end
        mag += g_step;
      end
      e_neg[nrec] = neg; e_sw[nrec] = sw; e_th[nrec] = th;
      e_seen[nrec] = seen; e_fail[nrec] = fl; nrec++;
      neg = 1 - neg;
    end
  endtask

  // pulse generator model
  initial forever begin
    bit r;
    int a;
    @(negedge clk);
    a = int'($signed(pls_amp_mv));
    if (prev_pwait) chk(pls_valid && a == prev_amp, "R10", "pulse request held", a, prev_amp);
    r = ($urandom % 2) == 0;
    pls_ready = r;
    if (pls_valid && rst_n) begin
      if (r) begin
        chk(pi < np && a == exp_amp[pi], "R3", "pulse amplitude", a, (pi < np) ? exp_amp[pi] : 99999);
        chk(rd_flag, "R2", "read before pulse", 0, 1);
        rd_flag = 0;
        dev_r = dev_apply(dev_r, a);
        pi++;
        prev_pwait = 0;
      end else begin
        prev_pwait = 1; prev_amp = a;
      end
    end else prev_pwait = 0;
  end

  // measurement model
  initial forever begin
    bit r;
    @(negedge clk);
    if (res_fire) begin rd_res_valid = 1'b0; res_fire = 0; end
    r = ($urandom % 2) == 0;
    rd_req_ready = r;
    if (rd_req_valid && r && rst_n) begin
      pend = 1; lat = $urandom % 3; nreads++; rd_flag = 1;
    end else if (pend && !rd_res_valid) begin
      if (lat == 0) begin
        rd_res_valid = 1'b1; rd_res_ohm = RES_W'(dev_r); pend = 0;
      end else lat--;
    end
    if (rd_res_valid && rd_res_ready) res_fire = 1;
  end

  // record consumer
  initial forever begin
    bit r;
    @(negedge clk);
    r = stall_mode ? (($urandom % 12) == 0) : (($urandom % 4) != 0);
    rec_ready = r;
    if (rec_valid && r && rst_n) begin
      if (ri < nrec) begin
        chk(int'(rec_neg) == e_neg[ri], "R4", "record polarity", int'(rec_neg), e_neg[ri]);
        chk(int'($signed(rec_sw_mv)) == e_sw[ri], e_fail[ri] ? "R7" : "R5", "switching voltage",
            int'($signed(rec_sw_mv)), e_sw[ri]);
        chk(int'(rec_fail) == e_fail[ri], "R7", "fail flag", int'(rec_fail), e_fail[ri]);
        chk(int'(rec_th_seen) == e_seen[ri], "R6", "threshold seen", int'(rec_th_seen), e_seen[ri]);
        chk(int'($signed(rec_th_mv)) == e_th[ri], "R6", "threshold voltage",
            int'($signed(rec_th_mv)), e_th[ri]);
      end else chk(0, "R8", "extra record", ri, nrec);
      ri++;
    end
  end

  task automatic run_test(input int st, input int sp, input int mx, input int lo, input int hi,
                          input int runs, input int neg, input int init_r,
                          input int sv, input int rv, input int sh, input int sm, input bit poke);
    int cnt;
    if (abort) return;
    g_start = st; g_step = sp; g_max = mx; g_lo = lo; g_hi = hi; g_runs = runs; g_neg = neg;
    setv = sv; rstv = rv; shf = sh; stall_mode = sm;
    build_expected(init_r);
    dev_r = init_r; pi = 0; ri = 0; nreads = 0; rd_flag = 0;
    @(negedge clk);
    cfg_start_mv = (AMP_W-1)'(st); cfg_step_mv = (AMP_W-1)'(sp); cfg_max_mv = (AMP_W-1)'(mx);
    cfg_r_lo = RES_W'(lo); cfg_r_hi = RES_W'(hi); cfg_runs = RUN_W'(runs);
    cfg_first_neg = neg[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: configuration changes after acceptance are ignored
    cfg_start_mv = 15'd7; cfg_max_mv = 15'd9; cfg_runs = 8'd3; cfg_first_neg = ~neg[0];
    if (poke) begin
      repeat (15) @(negedge clk);
      chk(busy, "R8", "busy during poke", int'(busy), 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    cnt = 0;
    while (!(ri >= nrec && !busy) && cnt < 40000) begin @(negedge clk); cnt++; end
    if (cnt >= 40000) begin
      chk(0, "WD", "watchdog expired", cnt, 0);
      abort = 1;
      return;
    end
    repeat (4) @(negedge clk);
    chk(!busy, "R8", "busy falls after session", int'(busy), 0);
    chk(ri == nrec, "R8", "record count", ri, nrec);
    chk(pi == np, "R3", "pulse count", pi, np);
    chk(nreads == np + nrec, "R2", "read count", nreads, np + nrec);
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !pls_valid && !rd_req_valid && !rec_valid, "R1", "outputs in reset",
        {busy, pls_valid, rd_req_valid, rec_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !pls_valid && !rd_req_valid && !rec_valid, "R1", "outputs after reset",
        {busy, pls_valid, rd_req_valid, rec_valid}, 0);

    run_test(100, 50, 1500, 5000, 10000, 4, 0, 8000, 600, 700, 4, 0, 0);   // base
    run_test(900, 50, 800, 5000, 10000, 2, 0, 8000, 600, 700, 4, 0, 0);    // R7 start above max
    run_test(100, 50, 600, 5000, 10000, 1, 0, 6000, 600, 700, 2, 0, 0);    // R7 reach at max
    run_test(100, 50, 1000, 5000, 10000, 2, 1, 8000, 5000, 5000, 4, 0, 0); // R6 never departs
    run_test(200, 100, 2000, 5000, 10000, 10, 1, 7000, 500, 600, 3, 1, 0); // R9 back-pressure
    run_test(100, 50, 2000, 5000, 10000, 5, 0, 8000, 1500, 1500, 5, 0, 1); // R8 poke while busy
    run_test(100, 50, 1000, 5000, 10000, 0, 0, 8000, 600, 700, 4, 0, 0);   // R8 zero runs

    for (int t = 0; t < 12; t++) begin
      int st, sp, mx, lo, hi;
      st = 50 + ($urandom % 12) * 50;
      case ($urandom % 3) 0: sp = 25; 1: sp = 50; default: sp = 100; endcase
      mx = st + ($urandom % 25) * sp + ($urandom % sp);
      lo = 4000 + $urandom % 2000;
      hi = lo + 3000 + $urandom % 4000;
      run_test(st, sp, mx, lo, hi, 1 + $urandom % 8, $urandom % 2, lo + $urandom % (hi - lo),
               100 + $urandom % 1500, 100 + $urandom % 1500, 2 + $urandom % 5,
               ($urandom % 4) == 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule